// File: doc/BRIEF.md
# Request Packetizer for a Credit-Flow Network Port

This block sits between a split-transaction initiator and one injection port of a packet-switched on-chip network. It takes one read or write request at a time on a valid/ready handshake. Each request carries an address, write data, a command bit and a transaction tag. The block turns the request into a short packet of 36-bit flits and sends one flit per cycle. Each flit has a 32-bit payload and four framing bits. The destination terminal comes from the top byte of the address. The tag travels in the header, so responses to several outstanding requests can return in any order and still be matched.

The network side carries no ready signal. Flow control is by credits. The block starts with as many credits as the downstream input buffer has slots. It spends one credit per flit and regains one for each single-cycle credit pulse the network returns. The state machine has four states. IDLE waits for a request. HDR sends the header. ADDR sends the address. DATA sends the write data. The transitions are:
- IDLE to HDR when a request is accepted.
- HDR to ADDR when the header flit leaves.
- ADDR to DATA when the address flit of a write leaves.
- ADDR to IDLE when the address flit of a read leaves.
- DATA to IDLE when the data flit leaves.

Each sending state holds its state while no credit is available.

Top module: `req_pktz`

## Requirements
- R1: After reset, req_ready is 1, flit_valid is 0, and the credit count is 4. Four flits can therefore leave before any credit returns.
- R2: The header flit payload holds the destination in bits [7:0], taken from req_addr[31:24]. It holds the tag in bits [15:8], the command in bit 16 (1 = write), zeros in bits [23:17] and the SRC_ID parameter in bits [31:24].
- R3: A write becomes three flits: header, then address, then write data. They leave on consecutive cycles when credits allow. The end-of-packet bit (flit bit 33) is set only on the data flit.
- R4: A read becomes two flits: header, then address. The end-of-packet bit is set on the address flit.
- R5: The begin-of-packet bit (flit bit 32) is set only on the header flit. Flit bits [35:34] are always 0. Begin and end are never set on the same flit.
- R6: No flit is sent while the credit count is zero. Each returned credit pulse allows exactly one further flit.
- R7: req_ready stays low from the cycle after acceptance until the cycle after the final flit. Changes on the request inputs during that time do not alter the packet being sent.
- R8: A credit pulse in the same cycle as a sent flit leaves the count unchanged. Back-to-back writes with per-flit credit return therefore run with a single idle cycle between packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 32 | Request address; top byte is the destination terminal |
| req_wdata | input | 32 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tag | input | 8 | Transaction tag |
| flit_valid | output | 1 | A flit is sent this cycle |
| flit_data | output | 36 | Flit: payload [31:0], begin [32], end [33], spare [35:34] |
| credit_in | input | 1 | One-cycle pulse returning one buffer slot |

## Verification
The assertions assume the network never returns more credits than it was given. In other words, a credit pulse with no flit in the same cycle never arrives while the count is already at its full value. The bench keeps to this in two ways. In one mode it echoes a credit in exactly the cycle a flit leaves. In the other it withholds credits and then returns only as many as it has consumed. The request inputs are driven only at falling edges, so they are held stable around each accepting edge.

// File: rtl/pktz_pkg.sv
`timescale 1ns/1ps
package pktz_pkg;
    localparam int PAYLOAD_W = 32;
    localparam int FRAME_W   = 4;
    localparam int FLIT_W    = PAYLOAD_W + FRAME_W;
    localparam int BOP_POS   = PAYLOAD_W;
    localparam int EOP_POS   = PAYLOAD_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_ADDR = 2'd2,
        ST_DATA = 2'd3
    } pk_state_e;
endpackage

// File: rtl/pktz_credit.sv
`timescale 1ns/1ps
module pktz_credit #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic send,
    input  logic credit_in,
    output logic can_send
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= FULL;
        end else begin
            unique case ({send, credit_in})
                2'b10:   cnt <= cnt - 1'b1;
                2'b01:   cnt <= cnt + 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign can_send = (cnt != '0);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send |-> (cnt != '0));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_in && !send) |-> (cnt < FULL));
endmodule

// File: rtl/pktz_hdr.sv
`timescale 1ns/1ps
module pktz_hdr #(
    parameter int          ADDR_W = 32,
    parameter int          DEST_W = 8,
    parameter int          TAG_W  = 8,
    parameter int          SRC_W  = 8,
    parameter logic [7:0]  SRC_ID = 8'h00
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [TAG_W-1:0]               tag,
    input  logic                           wr,
    output logic [pktz_pkg::PAYLOAD_W-1:0] hdr
);
    localparam int CMD_POS = DEST_W + TAG_W;
    localparam int PAD_W   = pktz_pkg::PAYLOAD_W - SRC_W - CMD_POS - 1;

    always_comb begin
        hdr = '0;
        hdr[DEST_W-1:0]                        = addr[ADDR_W-1 -: DEST_W];
        hdr[DEST_W +: TAG_W]                   = tag;
        hdr[CMD_POS]                           = wr;
        hdr[pktz_pkg::PAYLOAD_W-1 -: SRC_W]    = SRC_ID[SRC_W-1:0];
    end

    generate
        if (PAD_W < 0) begin : g_bad_layout
            initial $error("header fields exceed payload width");
        end
    endgenerate
endmodule

// File: rtl/pktz_fsm.sv
`timescale 1ns/1ps
module pktz_fsm
    import pktz_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      wr_q,
    input  logic      can_send,
    output logic      req_ready,
    output logic      capture,
    output logic      send,
    output logic      bop,
    output logic      eop,
    output pk_state_e state
);
    pk_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt       = state;
        req_ready = 1'b0;
        capture   = 1'b0;
        send      = 1'b0;
        bop       = 1'b0;
        eop       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    capture = 1'b1;
                    nxt     = ST_HDR;
                end
            end
            ST_HDR: begin
                send = can_send;
                bop  = 1'b1;
                if (can_send) nxt = ST_ADDR;
            end
            ST_ADDR: begin
                send = can_send;
                eop  = !wr_q;
                if (can_send) nxt = wr_q ? ST_DATA : ST_IDLE;
            end
            ST_DATA: begin
                send = can_send;
                eop  = 1'b1;
                if (can_send) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // R7
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send |-> !req_ready);

    // R7
    eop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (send && eop) |=> req_ready);

    // R3
    hdr_then_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (send && bop) |=> (state == ST_ADDR));
endmodule

// File: rtl/pktz_flit.sv
`timescale 1ns/1ps
module pktz_flit
    import pktz_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  pk_state_e              state,
    input  logic [PAYLOAD_W-1:0]   hdr,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic                   bop,
    input  logic                   eop,
    output logic [FLIT_W-1:0]      flit
);
    logic [PAYLOAD_W-1:0] pay;

    always_comb begin
        pay = '0;
        unique case (state)
            ST_HDR:  pay = hdr;
            ST_ADDR: pay = PAYLOAD_W'(addr);
            ST_DATA: pay = PAYLOAD_W'(wdata);
            default: pay = '0;
        endcase
    end

    genvar gi;
    generate
        for (gi = 0; gi < FRAME_W; gi++) begin : g_frame
            if (gi == 0) begin : g_b
                assign flit[PAYLOAD_W + gi] = bop;
            end else if (gi == 1) begin : g_e
                assign flit[PAYLOAD_W + gi] = eop;
            end else begin : g_z
                assign flit[PAYLOAD_W + gi] = 1'b0;
            end
        end
    endgenerate

    assign flit[PAYLOAD_W-1:0] = pay;
endmodule

// File: rtl/req_pktz.sv
`timescale 1ns/1ps
module req_pktz
    import pktz_pkg::*;
#(
    parameter int         ADDR_W  = 32,
    parameter int         DATA_W  = 32,
    parameter int         TAG_W   = 8,
    parameter int         DEST_W  = 8,
    parameter int         CREDITS = 4,
    parameter logic [7:0] SRC_ID  = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              flit_valid,
    output logic [FLIT_W-1:0] flit_data,
    input  logic              credit_in
);
    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    wdata_q;
    logic [TAG_W-1:0]     tag_q;
    logic                 wr_q;
    logic                 capture, send, bop, eop, can_send;
    pk_state_e            state;
    logic [PAYLOAD_W-1:0] hdr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            tag_q   <= '0;
            wr_q    <= 1'b0;
        end else if (capture) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            tag_q   <= req_tag;
            wr_q    <= req_write;
        end
    end

    pktz_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .wr_q      (wr_q),
        .can_send  (can_send),
        .req_ready (req_ready),
        .capture   (capture),
        .send      (send),
        .bop       (bop),
        .eop       (eop),
        .state     (state)
    );

    pktz_credit #(.DEPTH(CREDITS)) u_credit (
        .clk       (clk),
        .rst_n     (rst_n),
        .send      (send),
        .credit_in (credit_in),
        .can_send  (can_send)
    );

    pktz_hdr #(
        .ADDR_W (ADDR_W),
        .DEST_W (DEST_W),
        .TAG_W  (TAG_W),
        .SRC_W  (8),
        .SRC_ID (SRC_ID)
    ) u_hdr (
        .addr (addr_q),
        .tag  (tag_q),
        .wr   (wr_q),
        .hdr  (hdr)
    );

    pktz_flit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_flit (
        .state (state),
        .hdr   (hdr),
        .addr  (addr_q),
        .wdata (wdata_q),
        .bop   (bop),
        .eop   (eop),
        .flit  (flit_data)
    );

    assign flit_valid = send;

    // R5
    frame_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flit_valid |-> $onehot0(flit_data[EOP_POS:BOP_POS]));

    // R4
    read_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && state == ST_ADDR && !wr_q) |-> flit_data[EOP_POS]);

    // R2
    hdr_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && flit_data[BOP_POS]) |-> (flit_data[DEST_W+TAG_W] == wr_q));
endmodule

// File: tb/req_pktz_tb_top.sv
`timescale 1ns/1ps
module req_pktz_tb_top;
    localparam logic [7:0] SRC = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_tag = '0;
    logic        flit_valid;
    logic [35:0] flit_data;
    logic        credit_in;
    logic        man_cr = 1'b0;
    logic        auto_cr = 1'b1;
    logic        auto_pulse = 1'b0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int nlog = 0;
    logic [35:0] lg [64];
    int          lc [64];

    assign credit_in = man_cr | auto_pulse;

    always #4 clk = ~clk;

    req_pktz #(.SRC_ID(SRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
        .req_tag(req_tag), .flit_valid(flit_valid), .flit_data(flit_data),
        .credit_in(credit_in)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        auto_pulse = auto_cr && rst_n && flit_valid;
        if (rst_n && flit_valid && nlog < 64) begin
            lg[nlog] = flit_data;
            lc[nlog] = cyc;
            nlog = nlog + 1;
        end
    end

    function automatic logic [35:0] exp_flit(input logic [31:0] pay, input logic b, input logic e);
        return {2'b00, e, b, pay};
    endfunction

    function automatic logic [31:0] exp_hdr(input logic [31:0] a, input logic [7:0] t, input logic w);
        return {SRC, 7'b0, w, t, a[31:24]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_req(input logic [31:0] a, input logic [31:0] d, input logic w, input logic [7:0] t);
        req_addr = a; req_wdata = d; req_write = w; req_tag = t; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_pkt(input int base, input logic [31:0] a, input logic [31:0] d,
                             input logic w, input logic [7:0] t, input string req);
        chk(lg[base] == exp_flit(exp_hdr(a, t, w), 1'b1, 1'b0), {req, " header"},
            64'(lg[base]), 64'(exp_flit(exp_hdr(a, t, w), 1'b1, 1'b0)));
        chk(lg[base+1] == exp_flit(a, 1'b0, !w), {req, " address"},
            64'(lg[base+1]), 64'(exp_flit(a, 1'b0, !w)));
        chk(lc[base+1] == lc[base] + 1, {req, " address follows header"},
            64'(lc[base+1] - lc[base]), 64'd1);
        if (w) begin
            chk(lg[base+2] == exp_flit(d, 1'b0, 1'b1), {req, " data"},
                64'(lg[base+2]), 64'(exp_flit(d, 1'b0, 1'b1)));
            chk(lc[base+2] == lc[base] + 2, {req, " data follows address"},
                64'(lc[base+2] - lc[base]), 64'd2);
        end
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        chk(flit_valid == 1'b0, "R1 no flit after reset", 64'(flit_valid), 64'd0);
    endtask

    task automatic t_write();
        nlog = 0;
        send_req(32'hA3001234, 32'hDEADBEEF, 1'b1, 8'h17);
        wait_n(5);
        chk(nlog == 3, "R3 write flit count", 64'(nlog), 64'd3);
        check_pkt(0, 32'hA3001234, 32'hDEADBEEF, 1'b1, 8'h17, "R2 R3 R5 write");
    endtask

    task automatic t_read();
        nlog = 0;
        send_req(32'h0F00ABCD, 32'h11111111, 1'b0, 8'hC4);
        wait_n(5);
        chk(nlog == 2, "R4 read flit count", 64'(nlog), 64'd2);
        check_pkt(0, 32'h0F00ABCD, 32'h0, 1'b0, 8'hC4, "R2 R4 R5 read");
    endtask

    task automatic t_busy();
        nlog = 0;
        send_req(32'h7700FF00, 32'h01234567, 1'b1, 8'h3E);
        req_addr = 32'hFFFFFFFF; req_wdata = 32'h0; req_write = 1'b0; req_tag = 8'h00;
        for (int i = 0; i < 3; i++) begin
            chk(req_ready == 1'b0, "R7 ready low while sending", 64'(req_ready), 64'd0);
            @(negedge clk);
        end
        chk(req_ready == 1'b1, "R7 ready after final flit", 64'(req_ready), 64'd1);
        chk(flit_valid == 1'b0, "R7 idle after final flit", 64'(flit_valid), 64'd0);
        check_pkt(0, 32'h7700FF00, 32'h01234567, 1'b1, 8'h3E, "R7 held request");
    endtask

    task automatic t_b2b();
        nlog = 0;
        send_req(32'h01000001, 32'hAAAA0001, 1'b1, 8'h01);
        send_req(32'h02000002, 32'hAAAA0002, 1'b1, 8'h02);
        send_req(32'h03000003, 32'hAAAA0003, 1'b1, 8'h03);
        wait_n(6);
        chk(nlog == 9, "R8 back-to-back flit count", 64'(nlog), 64'd9);
        chk(lc[8] - lc[0] == 10, "R8 back-to-back span", 64'(lc[8] - lc[0]), 64'd10);
        check_pkt(6, 32'h03000003, 32'hAAAA0003, 1'b1, 8'h03, "R8 third packet");
    endtask

    task automatic t_credit();
        auto_cr = 1'b0;
        nlog = 0;
        send_req(32'hB0000010, 32'h5555AAAA, 1'b1, 8'h44);
        send_req(32'hB1000020, 32'h0, 1'b0, 8'h45);
        wait_n(6);
        chk(nlog == 4, "R1 R6 flits before stall", 64'(nlog), 64'd4);
        chk(flit_valid == 1'b0, "R6 stalled at zero credit", 64'(flit_valid), 64'd0);
        man_cr = 1'b1;
        @(negedge clk);
        man_cr = 1'b0;
        chk(flit_valid == 1'b1, "R6 credit releases one flit", 64'(flit_valid), 64'd1);
        wait_n(3);
        chk(nlog == 5, "R6 exactly one flit per credit", 64'(nlog), 64'd5);
        chk(lg[4] == exp_flit(32'hB1000020, 1'b0, 1'b1), "R4 R6 stalled read address",
            64'(lg[4]), 64'(exp_flit(32'hB1000020, 1'b0, 1'b1)));
        man_cr = 1'b1;
        wait_n(4);
        man_cr = 1'b0;
        auto_cr = 1'b1;
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_busy();
        t_b2b();
        t_credit();
        t_write();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule